// File: doc/BRIEF.md
# Age-Priority Issue Queue

This block holds renamed micro-operations between rename and execution. It has two sections: one for arithmetic work and one for memory work. Each stored entry keeps its operation kind, two source tags with ready flags, a destination tag, a branch color and a sequence number that gives its age. Up to four operations arrive per cycle in program order. Each arrival goes to its section. A branch is written into both sections and costs two of the four lanes. A group is taken whole or refused whole.

Result tags broadcast on the writeback lines set the matching ready flags. They also count toward readiness in the cycle of the broadcast, so a waiting operation can leave in that same cycle. In every cycle each section picks up to two ready entries by comparing all entries against each other in parallel. It orders them by age, oldest first, and the memory section puts loads ahead of everything else. A misprediction flush names a branch by its sequence number and removes every younger entry from both sections.

Top module: `age_issue_queue`

## Requirements
- R1: After reset both sections are empty: no issue port is valid, and a group of four ready arithmetic operations is accepted.
- R2: An entry is offered for issue only when both of its sources are ready. A younger ready entry may leave while an older entry with a pending source stays.
- R3: A tag on a valid writeback line counts as ready in the same cycle. A waiting entry whose last pending source is broadcast issues in that cycle, and a source that arrives together with a matching broadcast is stored as ready.
- R4: In the arithmetic section, issue port 0 gets the oldest ready entry and port 1 the next oldest. At most two entries leave per cycle, and an issued entry is removed.
- R5: In the memory section, ready loads (kind 1) rank before stores (kind 2) and branch copies (kind 3), whatever their age. Age then decides within each group.
- R6: An entry whose rank maps to a busy port does not issue that cycle and keeps its place. An entry ranked for a free port still issues.
- R7: Kind encoding: 0 arithmetic, 1 load, 2 store, 3 branch. Arithmetic goes to the arithmetic section, loads and stores go to the memory section, and a branch goes to both with the same destination, color and sequence number.
- R8: A group whose lane cost exceeds four is refused. A branch costs 2 and any other kind costs 1.
- R9: A group is refused when either section lacks free entries for its part of the group, and nothing from it is stored. A section with room keeps accepting when the other section is full.
- R10: A flush removes from both sections every entry younger than the flush sequence number, and keeps that entry and older ones. Insertion is refused in a flush cycle.
- R11: Sequence numbers start at 0 after reset. Each accepted valid lane takes the next number in lane order, lane 0 being the oldest. Issue ports show the sequence number and color of the issued entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Lane carries an operation |
| in_kind | input | LANES x 2 | Operation kind per lane |
| in_src0 | input | LANES x TAG_W | First source tag |
| in_src1 | input | LANES x TAG_W | Second source tag |
| in_src_rdy | input | LANES x 2 | Source ready flags (bit 0 first source) |
| in_dst | input | LANES x TAG_W | Destination tag |
| in_color | input | LANES x COLOR_W | Branch color |
| in_accept | output | 1 | Group is taken this cycle |
| wb_valid | input | WB_W | Writeback broadcast valid |
| wb_tag | input | WB_W x TAG_W | Broadcast result tag |
| flush_valid | input | 1 | Misprediction flush |
| flush_seq | input | SEQ_W | Sequence number of the mispredicted branch |
| alu_port_free | input | ISS_W | Arithmetic execution port can take work |
| mem_port_free | input | ISS_W | Memory execution port can take work |
| alu_iss_valid | output | ISS_W | Arithmetic issue valid per port |
| alu_iss_kind | output | ISS_W x 2 | Kind of issued entry |
| alu_iss_dst | output | ISS_W x TAG_W | Destination tag of issued entry |
| alu_iss_seq | output | ISS_W x SEQ_W | Sequence number of issued entry |
| alu_iss_color | output | ISS_W x COLOR_W | Color of issued entry |
| mem_iss_valid | output | ISS_W | Memory issue valid per port |
| mem_iss_kind | output | ISS_W x 2 | Kind of issued entry |
| mem_iss_dst | output | ISS_W x TAG_W | Destination tag of issued entry |
| mem_iss_seq | output | ISS_W x SEQ_W | Sequence number of issued entry |
| mem_iss_color | output | ISS_W x COLOR_W | Color of issued entry |

## Verification
The selector is exercised with several patterns. A batch of four ready operations shows strict age order across two cycles. An older entry that is blocked next to a younger ready one separates a readiness check from an age check. A store-load-store mix proves that load preference beats age. A busy port 0 shows that rank maps to a fixed port. Insertion is tried with a single branch, with a branch pair that costs exactly four lanes, and with three branches that exceed the budget. A filled arithmetic section with a free memory section tells a per-section capacity check apart from a global one. A flush in the middle of a blocked run checks that the boundary keeps the named entry and drops everything after it.

// File: rtl/iq_pkg.sv
package iq_pkg;

  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_BRANCH = 2'd3
  } uop_kind_e;

  // Operation needs an arithmetic-section entry.
  function automatic logic goes_alu(input logic [1:0] k);
    return (k == KIND_ALU) || (k == KIND_BRANCH);
  endfunction

  // Operation needs a memory-section entry.
  function automatic logic goes_mem(input logic [1:0] k);
    return (k != KIND_ALU);
  endfunction

  // Number of insertion lanes an operation consumes.
  function automatic logic [1:0] lane_cost(input logic [1:0] k);
    return (k == KIND_BRANCH) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/iq_select.sv
module iq_select #(
  parameter int N          = 28,
  parameter int ISS_W      = 2,
  parameter int SEQ_W      = 7,
  parameter int LOAD_FIRST = 0,
  localparam int IDX_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                req,
  input  logic [N-1:0][SEQ_W-1:0]     seq,
  input  logic [N-1:0]                lowpri,
  input  logic [ISS_W-1:0]            port_free,
  output logic [N-1:0]                grant,
  output logic [ISS_W-1:0]            port_valid,
  output logic [ISS_W-1:0][IDX_W-1:0] port_idx
);

  localparam int RANK_W = $clog2(N + 1);

  // a is older than b when a - b is negative in modular arithmetic.
  function automatic logic is_older(input logic [SEQ_W-1:0] a,
                                    input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  logic [N-1:0]      class_low;
  logic [RANK_W-1:0] rank     [N];
  logic [N-1:0]      port_hit [ISS_W];

  // The variant decides whether the class bit takes part in ranking.
  generate
    if (LOAD_FIRST != 0) begin : g_class_rank
      assign class_low = lowpri;
    end else begin : g_age_rank
      assign class_low = '0;
    end
  endgenerate

  // Rank of an entry = number of competing entries that beat it.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && req[j]) begin
          if ((!class_low[j] && class_low[i]) ||
              ((class_low[j] == class_low[i]) && is_older(seq[j], seq[i])))
            rank[i] = rank[i] + RANK_W'(1);
        end
      end
    end
  end

  always_comb begin
    grant = '0;
    for (int p = 0; p < ISS_W; p++) begin
      port_hit[p] = '0;
      port_idx[p] = '0;
      for (int i = 0; i < N; i++) begin
        if (req[i] && rank[i] == RANK_W'(p)) begin
          port_hit[p][i] = 1'b1;
          port_idx[p]    = port_idx[p] | IDX_W'(i);
          if (port_free[p]) grant[i] = 1'b1;
        end
      end
      port_valid[p] = (|port_hit[p]) && port_free[p];
    end
  end

  generate
    for (genvar p = 0; p < ISS_W; p++) begin : g_port_chk
      p_port_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_hit[p]));
    end
  endgenerate

  p_grant_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= ISS_W);

endmodule

// File: rtl/iq_section.sv
module iq_section import iq_pkg::*; #(
  parameter int DEPTH    = 28,
  parameter int LANES    = 4,
  parameter int ISS_W    = 2,
  parameter int WB_W     = 2,
  parameter int TAG_W    = 6,
  parameter int SEQ_W    = 7,
  parameter int COLOR_W  = 3,
  parameter int MEM_SIDE = 0,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ins_fire,
  input  logic [LANES-1:0]              lane_take,
  input  logic [LANES-1:0][1:0]         lane_kind,
  input  logic [LANES-1:0][TAG_W-1:0]   lane_src0,
  input  logic [LANES-1:0][TAG_W-1:0]   lane_src1,
  input  logic [LANES-1:0][1:0]         lane_rdy,
  input  logic [LANES-1:0][TAG_W-1:0]   lane_dst,
  input  logic [LANES-1:0][COLOR_W-1:0] lane_color,
  input  logic [LANES-1:0][SEQ_W-1:0]   lane_seq,
  input  logic [WB_W-1:0]               wb_valid,
  input  logic [WB_W-1:0][TAG_W-1:0]    wb_tag,
  input  logic                          flush_valid,
  input  logic [SEQ_W-1:0]              flush_seq,
  input  logic [ISS_W-1:0]              port_free,
  output logic [CNT_W-1:0]              free_cnt,
  output logic [ISS_W-1:0]              iss_valid,
  output logic [ISS_W-1:0][1:0]         iss_kind,
  output logic [ISS_W-1:0][TAG_W-1:0]   iss_dst,
  output logic [ISS_W-1:0][SEQ_W-1:0]   iss_seq,
  output logic [ISS_W-1:0][COLOR_W-1:0] iss_color
);

  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  function automatic logic is_older(input logic [SEQ_W-1:0] a,
                                    input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  function automatic logic tag_woken(input logic [TAG_W-1:0] t,
                                     input logic [WB_W-1:0] v,
                                     input logic [WB_W-1:0][TAG_W-1:0] tags);
    logic h;
    h = 1'b0;
    for (int w = 0; w < WB_W; w++) h = h | (v[w] && tags[w] == t);
    return h;
  endfunction

  // Entry storage
  logic [DEPTH-1:0]              e_valid;
  logic [DEPTH-1:0][1:0]         e_kind;
  logic [DEPTH-1:0][TAG_W-1:0]   e_src0, e_src1, e_dst;
  logic [DEPTH-1:0]              e_rdy0, e_rdy1;
  logic [DEPTH-1:0][COLOR_W-1:0] e_color;
  logic [DEPTH-1:0][SEQ_W-1:0]   e_seq;

  // Named internal events
  logic [DEPTH-1:0]              eff0, eff1, kill, req, lowpri, grant;
  logic [DEPTH-1:0]              wr_en;
  logic [LIDX_W-1:0]             wr_lane   [DEPTH];
  logic [CNT_W-1:0]              free_rank [DEPTH];
  logic [CNT_W-1:0]              lane_ord  [LANES];
  logic [CNT_W-1:0]              taken_cnt;
  logic [ISS_W-1:0][IDX_W-1:0]   port_idx;

  // Wakeup, flush kill and request vector
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      eff0[i]   = e_rdy0[i] | tag_woken(e_src0[i], wb_valid, wb_tag);
      eff1[i]   = e_rdy1[i] | tag_woken(e_src1[i], wb_valid, wb_tag);
      kill[i]   = flush_valid && e_valid[i] && is_older(flush_seq, e_seq[i]);
      req[i]    = e_valid[i] && eff0[i] && eff1[i] && !kill[i];
      lowpri[i] = (e_kind[i] != KIND_LOAD);
    end
  end

  // Parallel slot allocation: the n-th free entry takes the n-th lane
  always_comb begin
    free_cnt  = '0;
    taken_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      free_rank[i] = free_cnt;
      if (!e_valid[i]) free_cnt = free_cnt + CNT_W'(1);
    end
    for (int l = 0; l < LANES; l++) begin
      lane_ord[l] = taken_cnt;
      if (lane_take[l]) taken_cnt = taken_cnt + CNT_W'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      wr_en[i]   = 1'b0;
      wr_lane[i] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (ins_fire && !e_valid[i] && lane_take[l] &&
            lane_ord[l] == free_rank[i]) begin
          wr_en[i]   = 1'b1;
          wr_lane[i] = LIDX_W'(l);
        end
      end
    end
  end

  iq_select #(
    .N          (DEPTH),
    .ISS_W      (ISS_W),
    .SEQ_W      (SEQ_W),
    .LOAD_FIRST (MEM_SIDE)
  ) u_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .seq        (e_seq),
    .lowpri     (lowpri),
    .port_free  (port_free),
    .grant      (grant),
    .port_valid (iss_valid),
    .port_idx   (port_idx)
  );

  always_comb begin
    for (int p = 0; p < ISS_W; p++) begin
      iss_kind[p]  = e_kind[port_idx[p]];
      iss_dst[p]   = e_dst[port_idx[p]];
      iss_seq[p]   = e_seq[port_idx[p]];
      iss_color[p] = e_color[port_idx[p]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_kind  <= '0;
      e_src0  <= '0;
      e_src1  <= '0;
      e_dst   <= '0;
      e_rdy0  <= '0;
      e_rdy1  <= '0;
      e_color <= '0;
      e_seq   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en[i]) begin
          e_valid[i] <= 1'b1;
          e_kind[i]  <= lane_kind[wr_lane[i]];
          e_src0[i]  <= lane_src0[wr_lane[i]];
          e_src1[i]  <= lane_src1[wr_lane[i]];
          e_dst[i]   <= lane_dst[wr_lane[i]];
          e_color[i] <= lane_color[wr_lane[i]];
          e_seq[i]   <= lane_seq[wr_lane[i]];
          e_rdy0[i]  <= lane_rdy[wr_lane[i]][0] |
                        tag_woken(lane_src0[wr_lane[i]], wb_valid, wb_tag);
          e_rdy1[i]  <= lane_rdy[wr_lane[i]][1] |
                        tag_woken(lane_src1[wr_lane[i]], wb_valid, wb_tag);
        end else if (e_valid[i]) begin
          if (grant[i] || kill[i]) e_valid[i] <= 1'b0;
          e_rdy0[i] <= eff0[i];
          e_rdy1[i] <= eff1[i];
        end
      end
    end
  end

  // Checker state: flush point of the previous cycle
  logic [SEQ_W-1:0] fl_seq_q;
  logic [DEPTH-1:0] young_left;

  always_ff @(posedge clk) begin
    if (!rst_n) fl_seq_q <= '0;
    else        fl_seq_q <= flush_seq;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      young_left[i] = e_valid[i] && is_older(fl_seq_q, e_seq[i]);
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |-> (taken_cnt <= free_cnt));

  p_all_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |-> ($countones(wr_en) == $countones(lane_take)));

  p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(e_valid & eff0 & eff1)) == '0);

  p_issued_gone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> ((e_valid & $past(grant)) == '0));

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (young_left == '0));

endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue import iq_pkg::*; #(
  parameter int LANES     = 4,
  parameter int SEC_DEPTH = 28,
  parameter int ISS_W     = 2,
  parameter int WB_W      = 2,
  parameter int TAG_W     = 6,
  parameter int SEQ_W     = 7,
  parameter int COLOR_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              in_valid,
  input  logic [LANES-1:0][1:0]         in_kind,
  input  logic [LANES-1:0][TAG_W-1:0]   in_src0,
  input  logic [LANES-1:0][TAG_W-1:0]   in_src1,
  input  logic [LANES-1:0][1:0]         in_src_rdy,
  input  logic [LANES-1:0][TAG_W-1:0]   in_dst,
  input  logic [LANES-1:0][COLOR_W-1:0] in_color,
  output logic                          in_accept,
  input  logic [WB_W-1:0]               wb_valid,
  input  logic [WB_W-1:0][TAG_W-1:0]    wb_tag,
  input  logic                          flush_valid,
  input  logic [SEQ_W-1:0]              flush_seq,
  input  logic [ISS_W-1:0]              alu_port_free,
  input  logic [ISS_W-1:0]              mem_port_free,
  output logic [ISS_W-1:0]              alu_iss_valid,
  output logic [ISS_W-1:0][1:0]         alu_iss_kind,
  output logic [ISS_W-1:0][TAG_W-1:0]   alu_iss_dst,
  output logic [ISS_W-1:0][SEQ_W-1:0]   alu_iss_seq,
  output logic [ISS_W-1:0][COLOR_W-1:0] alu_iss_color,
  output logic [ISS_W-1:0]              mem_iss_valid,
  output logic [ISS_W-1:0][1:0]         mem_iss_kind,
  output logic [ISS_W-1:0][TAG_W-1:0]   mem_iss_dst,
  output logic [ISS_W-1:0][SEQ_W-1:0]   mem_iss_seq,
  output logic [ISS_W-1:0][COLOR_W-1:0] mem_iss_color
);

  localparam int CNT_W = $clog2(SEC_DEPTH + 1);
  localparam int SLT_W = $clog2(2 * LANES + 1);

  logic [SEQ_W-1:0]            seq_head;
  logic [LANES-1:0][SEQ_W-1:0] lane_seq;
  logic [LANES-1:0]            alu_take, mem_take;
  logic [CNT_W-1:0]            alu_need, mem_need, alu_free, mem_free;
  logic [SLT_W-1:0]            slot_sum;
  logic [SEQ_W-1:0]            n_valid;
  logic                        slots_ok, room_ok;

  // Group accounting: lane order is program order
  always_comb begin
    alu_need = '0;
    mem_need = '0;
    slot_sum = '0;
    n_valid  = '0;
    for (int l = 0; l < LANES; l++) begin
      lane_seq[l] = seq_head + n_valid;
      alu_take[l] = in_valid[l] && goes_alu(in_kind[l]);
      mem_take[l] = in_valid[l] && goes_mem(in_kind[l]);
      if (alu_take[l]) alu_need = alu_need + CNT_W'(1);
      if (mem_take[l]) mem_need = mem_need + CNT_W'(1);
      if (in_valid[l]) begin
        slot_sum = slot_sum + SLT_W'(lane_cost(in_kind[l]));
        n_valid  = n_valid + SEQ_W'(1);
      end
    end
    slots_ok  = (slot_sum <= SLT_W'(LANES));
    room_ok   = (alu_need <= alu_free) && (mem_need <= mem_free);
    in_accept = (|in_valid) && !flush_valid && slots_ok && room_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         seq_head <= '0;
    else if (in_accept) seq_head <= seq_head + n_valid;
  end

  iq_section #(
    .DEPTH (SEC_DEPTH), .LANES (LANES), .ISS_W (ISS_W), .WB_W (WB_W),
    .TAG_W (TAG_W), .SEQ_W (SEQ_W), .COLOR_W (COLOR_W), .MEM_SIDE (0)
  ) u_alu_sec (
    .clk (clk), .rst_n (rst_n), .ins_fire (in_accept), .lane_take (alu_take),
    .lane_kind (in_kind), .lane_src0 (in_src0), .lane_src1 (in_src1),
    .lane_rdy (in_src_rdy), .lane_dst (in_dst), .lane_color (in_color),
    .lane_seq (lane_seq), .wb_valid (wb_valid), .wb_tag (wb_tag),
    .flush_valid (flush_valid), .flush_seq (flush_seq),
    .port_free (alu_port_free), .free_cnt (alu_free),
    .iss_valid (alu_iss_valid), .iss_kind (alu_iss_kind), .iss_dst (alu_iss_dst),
    .iss_seq (alu_iss_seq), .iss_color (alu_iss_color)
  );

  iq_section #(
    .DEPTH (SEC_DEPTH), .LANES (LANES), .ISS_W (ISS_W), .WB_W (WB_W),
    .TAG_W (TAG_W), .SEQ_W (SEQ_W), .COLOR_W (COLOR_W), .MEM_SIDE (1)
  ) u_mem_sec (
    .clk (clk), .rst_n (rst_n), .ins_fire (in_accept), .lane_take (mem_take),
    .lane_kind (in_kind), .lane_src0 (in_src0), .lane_src1 (in_src1),
    .lane_rdy (in_src_rdy), .lane_dst (in_dst), .lane_color (in_color),
    .lane_seq (lane_seq), .wb_valid (wb_valid), .wb_tag (wb_tag),
    .flush_valid (flush_valid), .flush_seq (flush_seq),
    .port_free (mem_port_free), .free_cnt (mem_free),
    .iss_valid (mem_iss_valid), .iss_kind (mem_iss_kind), .iss_dst (mem_iss_dst),
    .iss_seq (mem_iss_seq), .iss_color (mem_iss_color)
  );

endmodule

// File: tb/age_issue_queue_tb.sv
`timescale 1ns/1ps
module age_issue_queue_tb;

  localparam int LANES = 4, DEPTH = 28, ISS_W = 2, WB_W = 2;
  localparam int TAG_W = 6, SEQ_W = 7, COLOR_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [LANES-1:0]              in_valid;
  logic [LANES-1:0][1:0]         in_kind;
  logic [LANES-1:0][TAG_W-1:0]   in_src0, in_src1, in_dst;
  logic [LANES-1:0][1:0]         in_src_rdy;
  logic [LANES-1:0][COLOR_W-1:0] in_color;
  logic                          in_accept;
  logic [WB_W-1:0]               wb_valid;
  logic [WB_W-1:0][TAG_W-1:0]    wb_tag;
  logic                          flush_valid;
  logic [SEQ_W-1:0]              flush_seq;
  logic [ISS_W-1:0]              alu_port_free, mem_port_free;
  logic [ISS_W-1:0]              alu_iss_valid, mem_iss_valid;
  logic [ISS_W-1:0][1:0]         alu_iss_kind, mem_iss_kind;
  logic [ISS_W-1:0][TAG_W-1:0]   alu_iss_dst, mem_iss_dst;
  logic [ISS_W-1:0][SEQ_W-1:0]   alu_iss_seq, mem_iss_seq;
  logic [ISS_W-1:0][COLOR_W-1:0] alu_iss_color, mem_iss_color;

  age_issue_queue u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_kind (in_kind), .in_src0 (in_src0),
    .in_src1 (in_src1), .in_src_rdy (in_src_rdy), .in_dst (in_dst),
    .in_color (in_color), .in_accept (in_accept),
    .wb_valid (wb_valid), .wb_tag (wb_tag),
    .flush_valid (flush_valid), .flush_seq (flush_seq),
    .alu_port_free (alu_port_free), .mem_port_free (mem_port_free),
    .alu_iss_valid (alu_iss_valid), .alu_iss_kind (alu_iss_kind),
    .alu_iss_dst (alu_iss_dst), .alu_iss_seq (alu_iss_seq),
    .alu_iss_color (alu_iss_color),
    .mem_iss_valid (mem_iss_valid), .mem_iss_kind (mem_iss_kind),
    .mem_iss_dst (mem_iss_dst), .mem_iss_seq (mem_iss_seq),
    .mem_iss_color (mem_iss_color)
  );

  int total = 0;
  int bad   = 0;
  int nseq  = 0;   // bench model of the next sequence number
  bit done  = 1'b0;

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic clr();
    in_valid      = '0;
    in_kind       = '0;
    in_src0       = '0;
    in_src1       = '0;
    in_src_rdy    = '1;
    in_dst        = '0;
    in_color      = '0;
    wb_valid      = '0;
    wb_tag        = '0;
    flush_valid   = 1'b0;
    flush_seq     = '0;
    alu_port_free = '1;
    mem_port_free = '1;
  endtask

  task automatic put(input int l, input int kind, input int s0, input int r0,
                     input int dst, input int color);
    in_valid[l]      = 1'b1;
    in_kind[l]       = 2'(kind);
    in_src0[l]       = TAG_W'(s0);
    in_src_rdy[l][0] = r0[0];
    in_src1[l]       = '0;
    in_src_rdy[l][1] = 1'b1;
    in_dst[l]        = TAG_W'(dst);
    in_color[l]      = COLOR_W'(color);
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  // R1, R4, R11: empty after reset, then strict age order over two cycles
  task automatic t_reset_and_age();
    put(0, 0, 0, 1, 1, 0); put(1, 0, 0, 1, 2, 0);
    put(2, 0, 0, 1, 3, 0); put(3, 0, 0, 1, 4, 0);
    @(negedge clk);
    chk("R1 alu idle after reset", alu_iss_valid, 0);
    chk("R1 mem idle after reset", mem_iss_valid, 0);
    chk("R1 four ready ops accepted", in_accept, 1);
    next_cycle(); clr();
    @(negedge clk);
    chk("R4 port0 oldest dst", alu_iss_dst[0], 1);
    chk("R11 port0 seq", alu_iss_seq[0], nseq);
    chk("R4 port1 next dst", alu_iss_dst[1], 2);
    chk("R11 port1 seq", alu_iss_seq[1], nseq + 1);
    chk("R4 two valid", alu_iss_valid, 3);
    next_cycle();
    @(negedge clk);
    chk("R4 second pair port0", alu_iss_dst[0], 3);
    chk("R4 second pair port1", alu_iss_dst[1], 4);
    next_cycle();
    @(negedge clk);
    chk("R4 drained", alu_iss_valid, 0);
    nseq += 4;
    next_cycle();
  endtask

  // R2, R3: older op waits on a tag, younger ready op passes it
  task automatic t_wakeup();
    int s;
    s = nseq;
    put(0, 0, 10, 0, 5, 0); put(1, 0, 0, 1, 6, 0);
    @(negedge clk);
    chk("R2 group accepted", in_accept, 1);
    nseq += 2;
    next_cycle(); clr();
    @(negedge clk);
    chk("R2 younger ready passes", alu_iss_dst[0], 6);
    chk("R2 younger seq", alu_iss_seq[0], s + 1);
    chk("R2 blocked op held", alu_iss_valid, 1);
    next_cycle();
    @(negedge clk);
    chk("R2 nothing ready", alu_iss_valid, 0);
    next_cycle();
    wb_valid[1] = 1'b1; wb_tag[1] = 6'd10;
    @(negedge clk);
    chk("R3 same-cycle wake issues", alu_iss_valid, 1);
    chk("R3 woken dst", alu_iss_dst[0], 5);
    chk("R3 woken seq", alu_iss_seq[0], s);
    next_cycle(); clr();
    @(negedge clk);
    chk("R4 woken op removed", alu_iss_valid, 0);
    // R3: source arriving with a matching broadcast is stored ready
    put(0, 0, 33, 0, 7, 0);
    wb_valid[0] = 1'b1; wb_tag[0] = 6'd33;
    next_cycle();
    clr();
    nseq += 1;
    @(negedge clk);
    chk("R3 captured at insert", alu_iss_dst[0], 7);
    next_cycle();
  endtask

  // R5: load outranks older stores in the memory section
  task automatic t_load_first();
    int s;
    s = nseq;
    put(0, 2, 0, 1, 8, 0); put(1, 1, 0, 1, 9, 0); put(2, 2, 0, 1, 10, 0);
    next_cycle(); clr();
    nseq += 3;
    @(negedge clk);
    chk("R5 load on port0", mem_iss_dst[0], 9);
    chk("R5 load kind", mem_iss_kind[0], 1);
    chk("R5 older store on port1", mem_iss_dst[1], 8);
    chk("R5 alu untouched", alu_iss_valid, 0);
    next_cycle();
    @(negedge clk);
    chk("R5 youngest store last", mem_iss_dst[0], 10);
    chk("R11 store seq", mem_iss_seq[0], s + 2);
    next_cycle();
  endtask

  // R6: busy port 0 holds the oldest entry
  task automatic t_busy_port();
    put(0, 0, 0, 1, 11, 0); put(1, 0, 0, 1, 12, 0);
    next_cycle(); clr();
    nseq += 2;
    alu_port_free = 2'b10;
    @(negedge clk);
    chk("R6 busy port silent", alu_iss_valid, 2);
    chk("R6 free port gets rank1", alu_iss_dst[1], 12);
    next_cycle(); clr();
    @(negedge clk);
    chk("R6 held op issues later", alu_iss_dst[0], 11);
    chk("R6 held op valid", alu_iss_valid, 1);
    next_cycle();
  endtask

  // R7, R8: branches go to both sections and cost two lanes
  task automatic t_branches();
    int s;
    s = nseq;
    put(0, 3, 0, 1, 13, 5);
    next_cycle(); clr();
    nseq += 1;
    @(negedge clk);
    chk("R7 branch alu copy", alu_iss_dst[0], 13);
    chk("R7 branch mem copy", mem_iss_dst[0], 13);
    chk("R7 copies share seq", mem_iss_seq[0], s);
    chk("R11 alu copy seq", alu_iss_seq[0], s);
    chk("R7 kind kept", alu_iss_kind[0], 3);
    chk("R11 color kept", mem_iss_color[0], 5);
    next_cycle();
    put(0, 3, 0, 1, 14, 1); put(1, 3, 0, 1, 15, 1); put(2, 3, 0, 1, 16, 1);
    @(negedge clk);
    chk("R8 six lanes refused", in_accept, 0);
    next_cycle(); clr();
    @(negedge clk);
    chk("R8 nothing stored", alu_iss_valid | mem_iss_valid, 0);
    next_cycle();
    put(0, 3, 0, 1, 14, 1); put(1, 3, 0, 1, 15, 1);
    @(negedge clk);
    chk("R8 four lanes accepted", in_accept, 1);
    next_cycle(); clr();
    nseq += 2;
    @(negedge clk);
    chk("R8 alu pair", alu_iss_valid, 3);
    chk("R8 mem pair", mem_iss_valid, 3);
    chk("R7 mem order", mem_iss_dst[1], 15);
    next_cycle();
  endtask

  // R9, R10: fill the arithmetic section, then flush part of it
  task automatic t_full_and_flush();
    int s;
    s = nseq;
    for (int g = 0; g < DEPTH / 4; g++) begin
      for (int l = 0; l < 4; l++) put(l, 0, 50, 0, 20 + 4 * g + l, 2);
      next_cycle(); clr();
    end
    nseq += DEPTH;
    put(0, 0, 0, 1, 60, 0);
    @(negedge clk);
    chk("R9 full section refuses", in_accept, 0);
    next_cycle(); clr();
    put(0, 1, 0, 1, 61, 0);
    @(negedge clk);
    chk("R9 other section accepts", in_accept, 1);
    next_cycle(); clr();
    nseq += 1;
    @(negedge clk);
    chk("R9 load issues", mem_iss_dst[0], 61);
    next_cycle();
    flush_valid = 1'b1; flush_seq = SEQ_W'(s + 1);
    put(0, 1, 0, 1, 62, 0);
    @(negedge clk);
    chk("R10 insert refused in flush", in_accept, 0);
    next_cycle(); clr();
    wb_valid[0] = 1'b1; wb_tag[0] = 6'd50;
    @(negedge clk);
    chk("R10 oldest kept", alu_iss_dst[0], 20);
    chk("R10 flush point kept", alu_iss_dst[1], 21);
    chk("R10 kept seq", alu_iss_seq[1], s + 1);
    next_cycle();
    @(negedge clk);
    chk("R10 younger removed", alu_iss_valid, 0);
    chk("R10 refused load absent", mem_iss_valid, 0);
    next_cycle(); clr();
    for (int l = 0; l < 4; l++) put(l, 0, 0, 1, 40 + l, 0);
    @(negedge clk);
    chk("R9 room after flush", in_accept, 1);
    next_cycle(); clr();
    @(negedge clk);
    chk("R11 numbering continues", alu_iss_seq[0], nseq);
    nseq += 4;
    next_cycle();
    next_cycle();
  endtask

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_and_age();
    t_wakeup();
    t_load_first();
    t_busy_port();
    t_branches();
    t_full_and_flush();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule